// File: doc/BRIEF.md
# LED Channel Startup Sequencer

This block is the digital controller that takes a multi-channel LED current-sink driver from power-up to steady operation. When enable goes high it enters a channel-detection phase: for a fixed number of boost switching cycles the sink pins are probed with a small current. At the final probe cycle, each channel's low-voltage comparator is sampled once. A channel whose pin is still near ground is treated as unused and is left out of the active-channel mask.

After detection the sequencer waits for the first rising edge of the PWM dimming input. It then runs a reduced-current ramp. During the ramp the soft-start flag tells the boost stage to use a lower current limit and the sinks to draw a fraction of the set current. The ramp lasts until the output-in-regulation flag is set, with no timeout. In normal operation each active sink follows the synchronized PWM level, gated by enable. An overcurrent request sends the block back to the ramp. Dropping enable returns the block to off from any state.

The analog sinks, the comparators and the boost loop are outside this block and appear only as digital inputs.

Top module: `led_startup_seq`

## Requirements
- R1: From off, a rising edge of `en_i` moves `state_o` to DETECT (code 1) on the next clock. While `en_i` is low, `state_o` becomes OFF (code 0) on the next clock from any state. The state codes are OFF=0, DETECT=1, WAIT_PWM=2, RAMP=3, NORMAL=4.
- R2: DETECT lasts exactly `DETECT_CYCLES` (default 512) cycles on which `sw_tick_i` is high. It ends on the clock edge that samples the last of those ticks. During DETECT `soft_start_o` is 1 and `sink_en_o` is 0.
- R3: When DETECT ends, `active_mask_o` is loaded with the inverse of `ch_low_i` as sampled on that last tick. A `ch_low_i` bit of 1 means the pin is below the grounded threshold. A mask bit of 1 means the channel is active.
- R4: WAIT_PWM (`soft_start_o` 1, sinks off) holds until a PWM rising edge arrives after a synchronizer of `SYNC_STAGES` flops. PWM edges that occur during DETECT are not counted. The block then enters RAMP, where `soft_start_o` is 1 and `sink_en_o` equals `active_mask_o` whatever the PWM level.
- R5: In RAMP, a high `vout_reg_i` moves the block to NORMAL on the next clock, and `soft_start_o` drops to 0.
- R6: In NORMAL, `sink_en_o` equals `active_mask_o` when both the synchronized PWM level and `en_i` are high, and is 0 otherwise. `en_i` gates the output without waiting for a clock.
- R7: In NORMAL, a high `ocp_fault_i` moves the block back to RAMP on the next clock. The active mask is kept.
- R8: RAMP has no timeout. Without `vout_reg_i` the block stays in RAMP indefinitely.
- R9: `active_mask_o` keeps its value through OFF. It is cleared to 0 on the next enable rising edge and is rebuilt only by the following detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Driver enable, synchronous to clk |
| pwm_i | input | 1 | PWM dimming input, asynchronous |
| sw_tick_i | input | 1 | One-cycle pulse per boost switching cycle |
| ch_low_i | input | NUM_CH | Per-channel flag: sink pin below grounded threshold |
| vout_reg_i | input | 1 | Output voltage has reached regulation |
| ocp_fault_i | input | 1 | Overcurrent fault request |
| active_mask_o | output | NUM_CH | Channels kept in the regulation loop |
| soft_start_o | output | 1 | Selects reduced boost limit and reduced sink current |
| sink_en_o | output | NUM_CH | Per-channel sink enable |
| state_o | output | 3 | Sequencer state code |

## Verification
On every cycle, the embedded assertions check the following: a low enable forces OFF; the detection counter stays inside its window; the sinks stay off during detection; the mask stays unchanged outside detection; a ramp is entered only after a PWM edge; NORMAL is entered only after regulation was seen. Other behaviours need a directed scenario in the bench. These are the exact number of ticks before detection ends, the mask pattern captured from the comparator flags, and the rejection of a PWM edge seen during detection. The bench also shows the RAMP state held for a long time without regulation, the mask kept through OFF, and the mask cleared and rebuilt on re-enable.

// File: rtl/led_seq_pkg.sv
// Package: shared state encoding for the LED startup sequencer.
// Assumes: the state codes are visible on state_o and are decoded by neighbours.
package led_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_DETECT = 3'd1,
        ST_WAIT   = 3'd2,
        ST_RAMP   = 3'd3,
        ST_NORMAL = 3'd4
    } seq_state_t;
endpackage

// File: rtl/seq_pwm_edge.sv
// Module: seq_pwm_edge
// Brings the asynchronous PWM input into the clk domain through a flop chain.
// Produces the synchronized level and a one-cycle pulse on its rising edge.
// Assumes: SYNC_STAGES >= 2.
module seq_pwm_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_async,
    output logic pwm_level,
    output logic pwm_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_d;

    // Synchronizer chain: shift the raw input toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pwm_async};
    end

    // Delay of the synchronized level, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= sync_q[SYNC_STAGES-1];
    end

    assign pwm_level = sync_q[SYNC_STAGES-1];
    assign pwm_rise  = sync_q[SYNC_STAGES-1] & ~level_d;
endmodule

// File: rtl/seq_detect_timer.sv
// Module: seq_detect_timer
// Counts switching-cycle ticks while run is high.
// Flags done on the tick that completes DETECT_CYCLES ticks.
// Assumes: run falls (or the counter restarts) once done has been seen.
module seq_detect_timer #(
    parameter int DETECT_CYCLES = 512,
    localparam int CNT_W = $clog2(DETECT_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DETECT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter: cleared whenever detection is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt_q <= '0;
        else if (tick) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run & tick & (cnt_q == LAST);

    assert_cnt_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(DETECT_CYCLES));

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/seq_mask_latch.sv
// Module: seq_mask_latch
// Holds the active-channel mask. clear empties it at an enable rising edge.
// capture loads it from the inverted low-pin flags when detection ends.
// Assumes: clear and capture are never high together.
module seq_mask_latch #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [NUM_CH-1:0] low_flags,
    output logic [NUM_CH-1:0] mask
);
    // Mask register: changes only on clear or capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) mask <= '0;
        else if (capture)    mask <= ~low_flags;
    end

    assert_ctl_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && capture));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !capture) |=> $stable(mask));
endmodule

// File: rtl/led_startup_seq.sv
// Module: led_startup_seq (top)
// Sequences a multi-channel LED sink driver through off, channel detection,
// wait for the first PWM edge, reduced-current ramp, and normal operation.
// Assumes: en_i, sw_tick_i, ch_low_i, vout_reg_i and ocp_fault_i are synchronous to clk.
// pwm_i may be asynchronous.
module led_startup_seq
    import led_seq_pkg::*;
#(
    parameter int NUM_CH        = 6,
    parameter int DETECT_CYCLES = 512,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              pwm_i,
    input  logic              sw_tick_i,
    input  logic [NUM_CH-1:0] ch_low_i,
    input  logic              vout_reg_i,
    input  logic              ocp_fault_i,
    output logic [NUM_CH-1:0] active_mask_o,
    output logic              soft_start_o,
    output logic [NUM_CH-1:0] sink_en_o,
    output logic [2:0]        state_o
);
    seq_state_t state_q, state_d;
    logic       en_q;
    logic       en_rise;
    logic       pwm_level, pwm_rise;
    logic       detect_done;
    logic       mask_clear;

    seq_pwm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pwm (
        .clk(clk), .rst_n(rst_n), .pwm_async(pwm_i),
        .pwm_level(pwm_level), .pwm_rise(pwm_rise)
    );

    seq_detect_timer #(.DETECT_CYCLES(DETECT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_DETECT),
        .tick(sw_tick_i), .done(detect_done)
    );

    assign en_rise    = en_i & ~en_q;
    assign mask_clear = (state_q == ST_OFF) & en_rise;

    seq_mask_latch #(.NUM_CH(NUM_CH)) u_mask (
        .clk(clk), .rst_n(rst_n), .clear(mask_clear), .capture(detect_done),
        .low_flags(ch_low_i), .mask(active_mask_o)
    );

    // State and enable-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_i;
        end
    end

    // Next-state logic: a low enable overrides every transition.
    always_comb begin
        state_d = state_q;
        if (!en_i) state_d = ST_OFF;
        else begin
            unique case (state_q)
                ST_OFF:    if (en_rise)     state_d = ST_DETECT;
                ST_DETECT: if (detect_done) state_d = ST_WAIT;
                ST_WAIT:   if (pwm_rise)    state_d = ST_RAMP;
                ST_RAMP:   if (vout_reg_i)  state_d = ST_NORMAL;
                ST_NORMAL: if (ocp_fault_i) state_d = ST_RAMP;
                default:                    state_d = ST_OFF;
            endcase
        end
    end

    // Output decode: soft-start flag and per-channel sink enables.
    always_comb begin
        soft_start_o = 1'b0;
        sink_en_o    = '0;
        unique case (state_q)
            ST_DETECT, ST_WAIT: soft_start_o = 1'b1;
            ST_RAMP: begin
                soft_start_o = 1'b1;
                sink_en_o    = active_mask_o & {NUM_CH{en_i}};
            end
            ST_NORMAL: sink_en_o = active_mask_o & {NUM_CH{pwm_level & en_i}};
            default: ;
        endcase
    end

    assign state_o = state_q;

    assert_off_on_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_o == 3'd0);

    assert_dark_in_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DETECT |-> sink_en_o == '0);

    assert_ramp_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAIT && state_q == ST_RAMP) |-> $past(pwm_rise));

    assert_normal_after_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RAMP && state_q == ST_NORMAL) |-> $past(vout_reg_i));

    assert_normal_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && sink_en_o != '0) |-> (en_i && pwm_level));

    assert_mask_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DETECT && $past(state_q) != ST_DETECT) |-> $stable(active_mask_o));
endmodule

// File: tb/tb_led_startup_seq.sv
// Directed bench for led_startup_seq. Inputs change on the falling edge;
// outputs are checked on the falling edge after the design's register update.
module tb_led_startup_seq;
    localparam int NCH = 6;
    localparam int DCY = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en_i = 1'b0, pwm_i = 1'b0, sw_tick_i = 1'b0;
    logic [NCH-1:0] ch_low_i = '0;
    logic           vout_reg_i = 1'b0, ocp_fault_i = 1'b0;
    logic [NCH-1:0] active_mask_o, sink_en_o;
    logic           soft_start_o;
    logic [2:0]     state_o;

    int vectors = 0;
    int miscompares = 0;
    logic [NCH-1:0] exp_mask;

    always #2.5 clk = ~clk;

    led_startup_seq #(.NUM_CH(NCH), .DETECT_CYCLES(DCY), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .pwm_i(pwm_i), .sw_tick_i(sw_tick_i),
        .ch_low_i(ch_low_i), .vout_reg_i(vout_reg_i), .ocp_fault_i(ocp_fault_i),
        .active_mask_o(active_mask_o), .soft_start_o(soft_start_o),
        .sink_en_o(sink_en_o), .state_o(state_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick;
        sw_tick_i = 1'b1; cyc(1);
        sw_tick_i = 1'b0; cyc(1);
    endtask

    // Reset values at the ports.
    task automatic t_reset;
        cyc(3); rst_n = 1'b1; cyc(1);
        chk("R1", "reset state", state_o, 0);
        chk("R9", "reset mask", active_mask_o, 0);
        chk("R2", "reset soft start", soft_start_o, 0);
        chk("R6", "reset sinks", sink_en_o, 0);
    endtask

    // Enable, run the full detection window, and check the captured mask.
    task automatic t_detect(input logic [NCH-1:0] low_pat);
        ch_low_i = ~low_pat;
        en_i = 1'b1; cyc(1);
        chk("R1", "enter detect", state_o, 1);
        chk("R2", "soft start in detect", soft_start_o, 1);
        chk("R9", "mask cleared at enable", active_mask_o, 0);
        for (int i = 0; i < DCY - 1; i++) begin
            if (i == 10) pwm_i = 1'b1;
            if (i == 20) pwm_i = 1'b0;
            if (i == DCY - 2) ch_low_i = low_pat;
            pulse_tick();
        end
        chk("R2", "still detect after last-but-one tick", state_o, 1);
        chk("R2", "sinks off in detect", sink_en_o, 0);
        pulse_tick();
        chk("R2", "detect ends on final tick", state_o, 2);
        exp_mask = ~low_pat;
        chk("R3", "captured mask", active_mask_o, exp_mask);
        ch_low_i = '1;
        cyc(10);
        chk("R4", "edge during detect ignored", state_o, 2);
        chk("R3", "mask ignores later flags", active_mask_o, exp_mask);
        chk("R4", "sinks off while waiting", sink_en_o, 0);
    endtask

    // First PWM edge starts the ramp; no regulation keeps it there.
    task automatic t_ramp;
        pwm_i = 1'b1; cyc(4);
        chk("R4", "ramp after pwm edge", state_o, 3);
        chk("R4", "soft start in ramp", soft_start_o, 1);
        chk("R4", "sinks on in ramp", sink_en_o, exp_mask);
        pwm_i = 1'b0; cyc(4);
        chk("R4", "ramp sinks independent of pwm", sink_en_o, exp_mask);
        for (int i = 0; i < 200; i++) pulse_tick();
        cyc(2000);
        chk("R8", "no ramp timeout", state_o, 3);
        chk("R8", "soft start held", soft_start_o, 1);
    endtask

    // Regulation reached: normal operation follows the PWM level.
    task automatic t_normal;
        vout_reg_i = 1'b1; cyc(1);
        chk("R5", "enter normal", state_o, 4);
        chk("R5", "soft start off", soft_start_o, 0);
        cyc(3);
        chk("R6", "pwm low sinks off", sink_en_o, 0);
        pwm_i = 1'b1; cyc(3);
        chk("R6", "pwm high sinks on", sink_en_o, exp_mask);
        pwm_i = 1'b0; cyc(3);
        chk("R6", "pwm low again", sink_en_o, 0);
        pwm_i = 1'b1; cyc(3);
    endtask

    // Overcurrent request returns to the ramp with the mask kept.
    task automatic t_ocp;
        vout_reg_i = 1'b0; ocp_fault_i = 1'b1; cyc(1);
        ocp_fault_i = 1'b0;
        chk("R7", "ocp to ramp", state_o, 3);
        chk("R7", "soft start again", soft_start_o, 1);
        chk("R7", "mask kept", active_mask_o, exp_mask);
        vout_reg_i = 1'b1; cyc(1);
        chk("R5", "back to normal", state_o, 4);
    endtask

    // Disable gates sinks at once, goes off, keeps mask; re-enable clears it.
    task automatic t_disable;
        en_i = 1'b0; #1;
        chk("R6", "enable gates sinks", sink_en_o, 0);
        cyc(1);
        chk("R1", "off after disable", state_o, 0);
        pwm_i = 1'b0; cyc(2); pwm_i = 1'b1; cyc(3); pulse_tick();
        chk("R1", "stays off", state_o, 0);
        chk("R9", "mask held in off", active_mask_o, exp_mask);
        en_i = 1'b1; cyc(1);
        chk("R9", "mask cleared on re-enable", active_mask_o, 0);
        chk("R1", "detect on re-enable", state_o, 1);
        for (int i = 0; i < 5; i++) pulse_tick();
        en_i = 1'b0; cyc(1);
        chk("R1", "disable mid-detect", state_o, 0);
        pwm_i = 1'b0; vout_reg_i = 1'b0; cyc(2);
    endtask

    initial begin
        t_reset();
        t_detect(6'b101101);
        t_ramp();
        t_normal();
        t_ocp();
        t_disable();
        t_detect(6'b000110);
        t_ramp();
        t_normal();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule